// File: doc/BRIEF.md
# External Interrupt Latch Controller

This block gathers one active-low external interrupt pin and a small group of keyboard-style port inputs into a single interrupt request for the CPU. All inputs are first passed through a two-flop synchroniser. Edges are then detected on the synchronised values. A falling edge on the pin, or a rising edge on any port input, sets a request latch. Two static options control the inputs. One chooses whether sensitivity is edge-only or edge-plus-level. The other chooses whether the port inputs take part. The port inputs are combined with the pin in inverted polarity, so a high level on a port input acts like a low level on the pin.

Software sees one control/status register. It holds an enable bit, a read-only pending flag and a write-one acknowledge bit. How the latch clears depends on the enable bit. With the enable clear, the CPU's vector-fetch strobe clears the latch. With the enable set, only an acknowledge write clears it. A low-power-entry strobe from the CPU forces the enable to 1. The request output is the pending flag ANDed with the enable. The CPU's global mask is applied outside this block.

Top module: `ext_irq_latch`

## Requirements
- R1: After reset the register reads 0x80 (enable set, pending clear) and the request output is low.
- R2: A falling edge on the pin sets the latch. The pending flag (bit 3) rises on the third rising clock edge after the pin changes and stays set after the pin returns high.
- R3: A rising edge on any port input sets the latch only while the port option is enabled. With the option disabled, port activity leaves pending and request unchanged.
- R4: In edge-plus-level mode (edge-only option low), a low pin level, or a high level on any port input while the port option is enabled, makes the pending flag read 1 for as long as the level is held.
- R5: In edge-only mode, a held level without a latched edge leaves the pending flag at 0.
- R6: Writing a 1 to bit 1 clears the latch. Bit 1 always reads 0. Writing bit 3 has no effect on the pending flag.
- R7: When the vector-fetch strobe is high and the enable is 0, the latch clears. When the enable is 1, the strobe leaves the latch unchanged.
- R8: The low-power-entry strobe sets the enable to 1 on the next edge, and it overrides a register write in the same cycle.
- R9: The request output equals pending AND enable in every cycle, so it stays high for as long as both are set.
- R10: An edge that sets the latch wins over an acknowledge or vector-fetch clear in the same cycle.
- R11: A register write stores bit 7 as the enable. Bits 6..4 and 2..0 always read 0. Read data is 0 when the select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_pin_ni | input | 1 | Active-low external interrupt pin (asynchronous) |
| kbd_i | input | 4 | Port inputs, active high (asynchronous) |
| opt_edge_only_i | input | 1 | Static option: 1 = edge-only, 0 = edge-plus-level |
| opt_kbd_en_i | input | 1 | Static option: port inputs take part |
| vec_fetch_i | input | 1 | CPU vector-fetch strobe |
| lp_entry_i | input | 1 | CPU stop/wait entry strobe |
| reg_cs_i | input | 1 | Register select |
| reg_we_i | input | 1 | Register write enable |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| irq_req_o | output | 1 | Interrupt request to CPU |

## Verification
The hardest case to reach is an edge arriving in the same cycle as an acknowledge write or a vector-fetch clear (R10). The pin travels through the synchroniser and the edge register, so the collision happens only if the write is issued exactly two cycles after the pin falls. The stimulus drives the pin and then places the write at that offset. The cycle-accurate reference model confirms that the latch survives. The enable-dependent vector-fetch behaviour is reached by first writing the enable to 0, then setting the latch, then strobing the fetch. The same fetch is then repeated with the enable set.

// File: rtl/eil_pkg.sv
package eil_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned EN_BIT   = 7;
  localparam int unsigned PEND_BIT = 3;
  localparam int unsigned ACK_BIT  = 1;
  localparam logic [REG_W-1:0] RESET_VIEW = REG_W'(1) << EN_BIT;
endpackage

// File: rtl/eil_sync.sv
module eil_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL[b]}};
      else if (STAGES > 1) chain_q <= {chain_q[STAGES-2:0], d_i[b]};
      else chain_q <= d_i[b];
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/eil_detect.sv
module eil_detect #(
  parameter int unsigned NKBD = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pin_n_s_i,
  input  logic [NKBD-1:0] kbd_s_i,
  input  logic            kbd_en_i,
  output logic            edge_evt_o,
  output logic            level_act_o
);
  logic            pin_prev_q;
  logic [NKBD-1:0] kbd_prev_q;
  logic [NKBD-1:0] kbd_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_prev_q <= 1'b1;
      kbd_prev_q <= '0;
    end else begin
      pin_prev_q <= pin_n_s_i;
      kbd_prev_q <= kbd_s_i;
    end
  end

  assign kbd_mask    = {NKBD{kbd_en_i}};
  // port lines join in inverted phase: rising port == falling pin
  assign edge_evt_o  = (pin_prev_q & ~pin_n_s_i) | (|(kbd_mask & kbd_s_i & ~kbd_prev_q));
  assign level_act_o = ~pin_n_s_i | (|(kbd_mask & kbd_s_i));
endmodule

// File: rtl/eil_csr.sv
module eil_csr
  import eil_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             edge_evt_i,
  input  logic             level_act_i,
  input  logic             edge_only_i,
  input  logic             vec_fetch_i,
  input  logic             lp_entry_i,
  input  logic             cs_i,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             irq_req_o,
  output logic             latch_o,
  output logic             en_o
);
  logic latch_q, en_q, wr, ack, auto_clr, pend;
  logic [REG_W-1:0] view;

  assign wr       = cs_i & we_i;
  assign ack      = wr & wdata_i[ACK_BIT];
  assign auto_clr = vec_fetch_i & ~en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= 1'b0;
      en_q    <= RESET_VIEW[EN_BIT];
    end else begin
      if (edge_evt_i)            latch_q <= 1'b1;
      else if (ack || auto_clr)  latch_q <= 1'b0;
      if (lp_entry_i)            en_q <= 1'b1;
      else if (wr)               en_q <= wdata_i[EN_BIT];
    end
  end

  assign pend = latch_q | (~edge_only_i & level_act_i);

  always_comb begin
    view           = '0;
    view[EN_BIT]   = en_q;
    view[PEND_BIT] = pend;
  end

  assign rdata_o   = cs_i ? view : '0;
  assign irq_req_o = pend & en_q;
  assign latch_o   = latch_q;
  assign en_o      = en_q;
endmodule

// File: rtl/ext_irq_latch.sv
module ext_irq_latch
  import eil_pkg::*;
#(
  parameter int unsigned NKBD        = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             irq_pin_ni,
  input  logic [NKBD-1:0]  kbd_i,
  input  logic             opt_edge_only_i,
  input  logic             opt_kbd_en_i,
  input  logic             vec_fetch_i,
  input  logic             lp_entry_i,
  input  logic             reg_cs_i,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             irq_req_o
);
  localparam int unsigned SW = NKBD + 1;
  localparam logic [SW-1:0] SYNC_RST = SW'(1);

  logic [SW-1:0]   sync_q;
  logic            edge_evt, level_act, latch_q, en_q;

  eil_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .d_i   ({kbd_i, irq_pin_ni}), .q_o(sync_q)
  );

  eil_detect #(.NKBD(NKBD)) u_det (
    .clk_i      (clk_i), .rst_ni(rst_ni),
    .pin_n_s_i  (sync_q[0]),
    .kbd_s_i    (sync_q[SW-1:1]),
    .kbd_en_i   (opt_kbd_en_i),
    .edge_evt_o (edge_evt),
    .level_act_o(level_act)
  );

  eil_csr u_csr (
    .clk_i      (clk_i), .rst_ni(rst_ni),
    .edge_evt_i (edge_evt), .level_act_i(level_act),
    .edge_only_i(opt_edge_only_i),
    .vec_fetch_i(vec_fetch_i), .lp_entry_i(lp_entry_i),
    .cs_i       (reg_cs_i), .we_i(reg_we_i), .wdata_i(reg_wdata_i),
    .rdata_o    (reg_rdata_o), .irq_req_o(irq_req_o),
    .latch_o    (latch_q), .en_o(en_q)
  );
endmodule

// File: rtl/ext_irq_latch_chk.sv
module ext_irq_latch_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_cs_i,
  input logic       reg_we_i,
  input logic [7:0] reg_wdata_i,
  input logic [7:0] reg_rdata_o,
  input logic       vec_fetch_i,
  input logic       lp_entry_i,
  input logic       opt_edge_only_i,
  input logic       irq_req_o,
  input logic       latch_q,
  input logic       en_q,
  input logic       edge_evt
);
  p_edge_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_evt |=> latch_q);
  p_edge_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_evt && reg_cs_i && reg_we_i && reg_wdata_i[1]) |=> latch_q);
  p_ack_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_cs_i && reg_we_i && reg_wdata_i[1] && !edge_evt) |=> !latch_q);
  p_vec_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_fetch_i && !en_q && !edge_evt) |=> !latch_q);
  p_vec_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_fetch_i && en_q && latch_q && !(reg_cs_i && reg_we_i && reg_wdata_i[1])) |=> latch_q);
  p_lp_enable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lp_entry_i |=> en_q);
  p_req_gated_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> en_q);
  p_req_latched_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_q && en_q) |-> irq_req_o);
  p_edge_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opt_edge_only_i && !latch_q) |-> !irq_req_o);
  p_zero_bits_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[6:4] == 3'b0) && (reg_rdata_o[2:0] == 3'b0));
endmodule

bind ext_irq_latch ext_irq_latch_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_cs_i(reg_cs_i), .reg_we_i(reg_we_i),
  .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .vec_fetch_i(vec_fetch_i),
  .lp_entry_i(lp_entry_i), .opt_edge_only_i(opt_edge_only_i), .irq_req_o(irq_req_o),
  .latch_q(latch_q), .en_q(en_q), .edge_evt(edge_evt)
);

// File: tb/ext_irq_latch_bench.sv
`timescale 1ns/1ps
module ext_irq_latch_bench;
  logic       clk = 0, rst_n = 0;
  logic       pin_n = 1;
  logic [3:0] kbd = 0;
  logic       edge_only = 1, kbd_en = 1, vec = 0, lp = 0;
  logic       cs = 1, we = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic       req;

  int checks = 0, errors = 0, cyc = 0;
  string cur_req = "R1";
  bit done = 0;

  always #5 clk = ~clk;

  ext_irq_latch u_ext_irq_latch (
    .clk_i(clk), .rst_ni(rst_n), .irq_pin_ni(pin_n), .kbd_i(kbd),
    .opt_edge_only_i(edge_only), .opt_kbd_en_i(kbd_en),
    .vec_fetch_i(vec), .lp_entry_i(lp), .reg_cs_i(cs), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_req_o(req)
  );

  // behavioural reference model
  bit       m_p1, m_p2, m_pprev, m_latch, m_en;
  bit [3:0] m_k1, m_k2, m_kprev;

  function automatic bit m_pend();
    bit lvl;
    lvl = !m_p2 || (kbd_en && m_k2 != 0);
    return m_latch || (!edge_only && lvl);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_p1 = 1; m_p2 = 1; m_pprev = 1; m_k1 = 0; m_k2 = 0; m_kprev = 0;
      m_latch = 0; m_en = 1;
    end else begin
      bit ev, clr;
      ev  = (m_pprev && !m_p2) || (kbd_en && ((m_k2 & ~m_kprev) != 0));
      clr = (cs && we && wdata[1]) || (vec && !m_en);
      if (ev) m_latch = 1; else if (clr) m_latch = 0;
      if (lp) m_en = 1; else if (cs && we) m_en = wdata[7];
      m_pprev = m_p2; m_kprev = m_k2;
      m_p2 = m_p1; m_k2 = m_k1;
      m_p1 = pin_n; m_k1 = kbd;
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h cycle %0d", cur_req, what, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    #3;
    if (rst_n && !done) begin
      bit [7:0] exp_rd;
      exp_rd = cs ? {m_en, 3'b000, m_pend(), 3'b000} : 8'h00;
      chk("rdata", rdata, exp_rd);
      chk("irq_req", req, m_pend() && m_en);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk); cs = 1; we = 1; wdata = d;
    @(negedge clk); we = 0; wdata = 0;
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(2); rst_n = 1;
    cur_req = "R1"; idle(1);
    chk("R1 reset view", rdata, 8'h80);
    chk("R1 reset req", req, 0);
    idle(2);

    cur_req = "R2";
    @(negedge clk); pin_n = 0;
    idle(3); chk("R2 pend set", rdata[3], 1);
    pin_n = 1; idle(5); chk("R2 held after release", rdata[3], 1);

    cur_req = "R6";
    wr(8'h8A); idle(1); chk("R6 ack clears", rdata, 8'h80);
    wr(8'h88); idle(1); chk("R6 pend not writable", rdata, 8'h80);

    cur_req = "R3";
    @(negedge clk); kbd = 4'b0100; idle(5);
    chk("R3 port edge", rdata[3], 1);
    kbd = 0; wr(8'h82); kbd_en = 0; idle(2);
    @(negedge clk); kbd = 4'b1001; idle(5);
    chk("R3 port ignored", rdata[3], 0);
    kbd = 0; idle(4); kbd_en = 1; idle(3);

    cur_req = "R5";
    @(negedge clk); pin_n = 0; idle(5);
    wr(8'h82); idle(5); chk("R5 level ignored", rdata[3], 0);
    pin_n = 1; idle(4);

    cur_req = "R4";
    edge_only = 0; idle(1);
    @(negedge clk); kbd = 4'b0010; idle(4);
    wr(8'h82); idle(2); chk("R4 port level", rdata[3], 1);
    kbd = 0; idle(4); chk("R4 level gone", rdata[3], 0);
    @(negedge clk); pin_n = 0; idle(4);
    wr(8'h82); idle(2); chk("R4 pin level", rdata[3], 1);
    pin_n = 1; idle(4); chk("R4 pin gone", rdata[3], 0);
    edge_only = 1; idle(2);

    cur_req = "R7";
    wr(8'h00);
    @(negedge clk); pin_n = 0; idle(4); pin_n = 1; idle(3);
    chk("R7 latched, req gated", req, 0);
    @(negedge clk); vec = 1; @(negedge clk); vec = 0;
    cs = 1; wr(8'h80); chk("R7 cleared by fetch", rdata[3], 0);
    @(negedge clk); pin_n = 0; idle(4); pin_n = 1; idle(3);
    @(negedge clk); vec = 1; @(negedge clk); vec = 0; idle(1);
    chk("R7 fetch kept latch", rdata[3], 1);

    cur_req = "R9";
    idle(6); chk("R9 req continuous", req, 1);
    wr(8'h02); idle(1); chk("R9 req drops with enable", req, 0);

    cur_req = "R8";
    @(negedge clk); lp = 1; @(negedge clk); lp = 0; idle(1);
    chk("R8 enable forced", rdata[7], 1);
    @(negedge clk); lp = 1; cs = 1; we = 1; wdata = 8'h00;
    @(negedge clk); lp = 0; we = 0; idle(1);
    chk("R8 overrides write", rdata[7], 1);

    cur_req = "R10";
    @(negedge clk); pin_n = 0;
    @(negedge clk); @(negedge clk);
    cs = 1; we = 1; wdata = 8'h82;
    @(negedge clk); we = 0; wdata = 0; pin_n = 1; idle(1);
    chk("R10 edge beats ack", rdata[3], 1);
    wr(8'h02);
    @(negedge clk); pin_n = 0; @(negedge clk); @(negedge clk);
    vec = 1; @(negedge clk); vec = 0; pin_n = 1; idle(1);
    chk("R10 edge beats fetch", rdata[3], 1);

    cur_req = "R11";
    wr(8'h7F); idle(1); chk("R11 write view", rdata, 8'h00);
    cs = 0; idle(2); chk("R11 deselected", rdata, 8'h00);
    cs = 1; wr(8'h80); idle(2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule